// File: doc/BRIEF.md
# Redundant Manager Role Arbiter

This block runs on each of two redundant chassis management units and decides which one of them holds the active role. Each unit drives an isolation line toward the other unit's status buffer. A unit reads its own role from the isolation line it receives: if the peer is holding it isolated, the unit is standby, otherwise it is free to take the active role. After reset, a unit waits for a delay set by its slot number. It then claims the active role only if its own status still reads free. The first unit to finish its delay therefore wins. When both units start together, the lower slot wins, and slot 0 is the main slot.

Once roles are settled, the standby unit watches the heartbeat pulses that come from the active unit. Suppose these pulses stop for a set number of cycles while the board heartbeats still look healthy. The standby unit then drives a hard-reset pulse into its peer. While the failed unit is held in reset it drops its isolation line. The standby unit then reads free and takes over. When the reset unit comes back, it contends again, finds itself isolated, and settles as standby. Two instances are cross-coupled to form the pair: each unit's isolation output feeds the other's isolation input, and each unit's reset output feeds the other's reset-request input.

Top module: `duo_role_arbiter`

## Requirements
- R1: While `rst` or `hard_rst_i` is high, and after reset until the role decision, `standby_o` is 1, `peer_iso_o` is 0 and `peer_rst_o` is 0.
- R2: The unit's own status is `peer_iso_i`, where 1 means standby (isolated by the peer) and 0 means free to be active. It passes through two flip-flops before any decision uses it.
- R3: The first rising edge with reset low samples the slot. The role decision is taken on edge number slot_id_i*DELAY_STEP+4 counted from that point, and `standby_o` changes on that edge.
- R4: At the decision, a free status makes the unit active, with `standby_o`=0 and `peer_iso_o`=1. An isolated status makes it standby, with `standby_o`=1 and `peer_iso_o`=0.
- R5: When both units leave reset together, the unit in the lower slot becomes active. When one unit has already decided, it stays active even if the later unit sits in a lower slot.
- R6: In standby, the heartbeat timeout expires after HB_TIMEOUT consecutive cycles with `peer_hb_i` low. Any heartbeat pulse restarts the count, so pulses spaced 500 cycles apart (default HB_TIMEOUT=500) never expire it.
- R7: When the timeout has expired in standby with `board_ok_i`=1, `peer_rst_o` goes high for exactly RST_W cycles (default 8), once for each expiry.
- R8: While `board_ok_i` is 0, an expired timeout raises no `peer_rst_o`, and the roles stay as they are.
- R9: An active unit never raises `peer_rst_o`, even when it receives no heartbeats.
- R10: A standby unit whose synchronised status reads 0 becomes active on the next clock, with `standby_o`=0 and `peer_iso_o`=1.
- R11: `hard_rst_i` acts as a reset. A unit reset this way contends again, reads status 1 and settles as standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| hard_rst_i | input | 1 | Hard reset request from the peer unit |
| slot_id_i | input | SLOT_W | Slot number; 0 is the main slot |
| peer_iso_i | input | 1 | Isolation line from the peer; 1 = this unit is standby |
| peer_hb_i | input | 1 | One-cycle heartbeat pulse from the peer |
| board_ok_i | input | 1 | Board heartbeats are still being seen |
| peer_iso_o | output | 1 | Isolation line toward the peer's status buffer |
| standby_o | output | 1 | Role: 0 active, 1 standby |
| peer_rst_o | output | 1 | Hard-reset pulse to the peer |

## Verification
The hardest case to reach is a complete takeover. The standby unit must see the heartbeat go quiet with board health still good, then reset the active unit, take over within that reset window, and finally watch the old active unit come back and settle as standby. The bench wires two instances back to back and reaches this case by stopping only the heartbeat into the standby unit, never resetting anything directly. It first stretches the heartbeat spacing to just under the timeout, then to just over it, which also pins down the exact timeout boundary. Near-tie contention is reached through staggered reset releases taken from the vector table.

// File: rtl/duo_role_pkg.sv
package duo_role_pkg;

    typedef enum logic [1:0] {
        RS_SLOT    = 2'd0,
        RS_DELAY   = 2'd1,
        RS_ACTIVE  = 2'd2,
        RS_STANDBY = 2'd3
    } role_st_e;

    // Status value read through the own buffer
    localparam logic STATUS_FREE     = 1'b0;
    localparam logic STATUS_ISOLATED = 1'b1;

    // Cycles added to every start delay so the status synchroniser has settled
    localparam int unsigned SETTLE_CYC = 2;

    typedef struct packed {
        logic iso;
        logic standby;
    } role_drive_t;

    localparam role_drive_t DRIVE_WAIT   = '{iso: 1'b0, standby: 1'b1};
    localparam role_drive_t DRIVE_ACTIVE = '{iso: 1'b1, standby: 1'b0};

    function automatic int unsigned start_wait(input int unsigned slot,
                                               input int unsigned step);
        return slot * step + SETTLE_CYC;
    endfunction

endpackage

// File: rtl/rsa_sync2.sv
module rsa_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/rsa_start_delay.sv
module rsa_start_delay
    import duo_role_pkg::*;
#(
    parameter int unsigned SLOT_W = 2,
    parameter int unsigned STEP   = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic              done_o
);
    localparam int unsigned MAX_WAIT = ((1 << SLOT_W) - 1) * STEP + SETTLE_CYC;
    localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CNT_W'(start_wait(32'(slot_i), STEP));
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign done_o = (cnt_q == '0);

    assert_delay_bound_R3: assert property (@(posedge clk) disable iff (rst)
        32'(cnt_q) <= MAX_WAIT);

    assert_delay_counts_down_R3: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/rsa_hb_watch.sv
module rsa_hb_watch #(
    parameter int unsigned TIMEOUT = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic hb_i,
    input  logic clear_i,
    output logic expired_o
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!arm_i || hb_i || clear_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_W'(TIMEOUT)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign expired_o = (cnt_q == CNT_W'(TIMEOUT));

    assert_hb_bound_R6: assert property (@(posedge clk) disable iff (rst)
        32'(cnt_q) <= TIMEOUT);

    assert_hb_restart_R6: assert property (@(posedge clk) disable iff (rst)
        hb_i |=> (cnt_q == '0));
endmodule

// File: rtl/rsa_rst_pulse.sv
module rsa_rst_pulse #(
    parameter int unsigned WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    output logic pulse_o
);
    localparam int unsigned CNT_W = $clog2(WIDTH + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == CNT_W'(WIDTH - 1)) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end else if (fire_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end
    end

    assign pulse_o = busy_q;

    assert_pulse_len_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> ($past(cnt_q) == CNT_W'(WIDTH - 1)));

    assert_pulse_bound_R7: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (32'(cnt_q) < WIDTH));
endmodule

// File: rtl/duo_role_arbiter.sv
module duo_role_arbiter
    import duo_role_pkg::*;
#(
    parameter int unsigned SLOT_W     = 2,
    parameter int unsigned DELAY_STEP = 100,
    parameter int unsigned HB_TIMEOUT = 500,
    parameter int unsigned RST_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hard_rst_i,
    input  logic [SLOT_W-1:0] slot_id_i,
    input  logic              peer_iso_i,
    input  logic              peer_hb_i,
    input  logic              board_ok_i,
    output logic              peer_iso_o,
    output logic              standby_o,
    output logic              peer_rst_o
);
    logic        unit_rst;
    logic        status_q;
    logic        dly_load, dly_done;
    logic        hb_arm, hb_expired;
    logic        fire;
    role_st_e    st_q, st_d;
    role_drive_t drv_q, drv_d;

    assign unit_rst = rst | hard_rst_i;

    rsa_sync2 #(.RST_VAL(STATUS_ISOLATED)) u_status_sync (
        .clk (clk),
        .rst (unit_rst),
        .d_i (peer_iso_i),
        .q_o (status_q)
    );

    rsa_start_delay #(.SLOT_W(SLOT_W), .STEP(DELAY_STEP)) u_start_delay (
        .clk    (clk),
        .rst    (unit_rst),
        .load_i (dly_load),
        .slot_i (slot_id_i),
        .done_o (dly_done)
    );

    rsa_hb_watch #(.TIMEOUT(HB_TIMEOUT)) u_hb_watch (
        .clk       (clk),
        .rst       (unit_rst),
        .arm_i     (hb_arm),
        .hb_i      (peer_hb_i),
        .clear_i   (peer_rst_o),
        .expired_o (hb_expired)
    );

    rsa_rst_pulse #(.WIDTH(RST_W)) u_rst_pulse (
        .clk     (clk),
        .rst     (unit_rst),
        .fire_i  (fire),
        .pulse_o (peer_rst_o)
    );

    assign dly_load = (st_q == RS_SLOT);
    assign hb_arm   = (st_q == RS_STANDBY);
    assign fire     = hb_arm && hb_expired && board_ok_i && !peer_rst_o;

    always_comb begin
        st_d  = st_q;
        drv_d = drv_q;
        case (st_q)
            RS_SLOT: st_d = RS_DELAY;
            RS_DELAY: begin
                if (dly_done) begin
                    if (status_q == STATUS_FREE) begin
                        st_d  = RS_ACTIVE;
                        drv_d = DRIVE_ACTIVE;
                    end else begin
                        st_d  = RS_STANDBY;
                        drv_d = DRIVE_WAIT;
                    end
                end
            end
            RS_STANDBY: begin
                if (status_q == STATUS_FREE) begin
                    st_d  = RS_ACTIVE;
                    drv_d = DRIVE_ACTIVE;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (unit_rst) begin
            st_q  <= RS_SLOT;
            drv_q <= DRIVE_WAIT;
        end else begin
            st_q  <= st_d;
            drv_q <= drv_d;
        end
    end

    assign peer_iso_o = drv_q.iso;
    assign standby_o  = drv_q.standby;

    assert_wait_standby_R1: assert property (@(posedge clk) disable iff (unit_rst)
        (st_q == RS_SLOT || st_q == RS_DELAY) |-> (standby_o && !peer_iso_o && !peer_rst_o));

    assert_claim_needs_free_R4: assert property (@(posedge clk) disable iff (unit_rst)
        $rose(peer_iso_o) |-> ($past(status_q) == STATUS_FREE));

    assert_active_isolates_R10: assert property (@(posedge clk) disable iff (unit_rst)
        !standby_o |-> peer_iso_o);

    assert_active_sticky_R10: assert property (@(posedge clk) disable iff (unit_rst)
        $fell(standby_o) |=> !standby_o);

    assert_fire_from_standby_R9: assert property (@(posedge clk) disable iff (unit_rst)
        $rose(peer_rst_o) |-> $past(st_q == RS_STANDBY && board_ok_i));
endmodule

// File: tb/duo_role_arbiter_tb.sv
module duo_role_arbiter_tb;
    localparam int STEP = 100;
    localparam int RSTW = 8;

    logic       clk = 1'b0;
    logic       rst_a = 1'b1, rst_b = 1'b1;
    logic [1:0] slot_a = 2'd0, slot_b = 2'd1;
    logic       hb_a = 1'b0, hb_b = 1'b0;
    logic       ok_a = 1'b1, ok_b = 1'b1;
    logic       iso_a, iso_b, sb_a, sb_b, prst_a, prst_b;

    int  total = 0, bad = 0;
    bit  wd_hit = 1'b0;
    bit  en_hb_a = 1'b1, en_hb_b = 1'b1;
    int  per_a = 100, per_b = 100;
    int  ph_a = 0, ph_b = 0;
    int  rise_a = 0, rise_b = 0, hi_a = 0, hi_b = 0;
    logic prst_a_d = 1'b0, prst_b_d = 1'b0;

    always #5 clk = ~clk;

    duo_role_arbiter u_dut (
        .clk(clk), .rst(rst_a), .hard_rst_i(prst_b), .slot_id_i(slot_a),
        .peer_iso_i(iso_b), .peer_hb_i(hb_a), .board_ok_i(ok_a),
        .peer_iso_o(iso_a), .standby_o(sb_a), .peer_rst_o(prst_a)
    );

    duo_role_arbiter u_peer (
        .clk(clk), .rst(rst_b), .hard_rst_i(prst_a), .slot_id_i(slot_b),
        .peer_iso_i(iso_a), .peer_hb_i(hb_b), .board_ok_i(ok_b),
        .peer_iso_o(iso_b), .standby_o(sb_b), .peer_rst_o(prst_b)
    );

    // Reset pulse monitor
    always @(negedge clk) begin
        if (prst_a) hi_a++;
        if (prst_b) hi_b++;
        if (prst_a && !prst_a_d) rise_a++;
        if (prst_b && !prst_b_d) rise_b++;
        prst_a_d = prst_a;
        prst_b_d = prst_b;
    end

    // Heartbeat generators: hb_a is the heartbeat unit A receives from B
    initial begin
        fork
            forever begin
                @(negedge clk);
                if (en_hb_a) begin
                    if (ph_a >= per_a - 1) begin hb_a = 1'b1; ph_a = 0; end
                    else begin hb_a = 1'b0; ph_a++; end
                end else hb_a = 1'b0;
            end
            forever begin
                @(negedge clk);
                if (en_hb_b) begin
                    if (ph_b >= per_b - 1) begin hb_b = 1'b1; ph_b = 0; end
                    else begin hb_b = 1'b0; ph_b++; end
                end else hb_b = 1'b0;
            end
        join_none
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0] sa;
        logic [1:0] sb;
        int         ra;
        int         rb;
        logic       ea;
        logic       eb;
    } vec_t;

    // slot A, slot B, release cycle A, release cycle B, expected standby A, B
    localparam vec_t VEC [8] = '{
        '{2'd1, 2'd0, 0,   0,   1'b1, 1'b0},
        '{2'd2, 2'd3, 0,   0,   1'b0, 1'b1},
        '{2'd3, 2'd1, 0,   0,   1'b1, 1'b0},
        '{2'd3, 2'd0, 0,   500, 1'b0, 1'b1},
        '{2'd0, 2'd2, 600, 0,   1'b1, 1'b0},
        '{2'd0, 2'd1, 90,  0,   1'b0, 1'b1},
        '{2'd0, 2'd1, 200, 0,   1'b1, 1'b0},
        '{2'd0, 2'd1, 0,   0,   1'b0, 1'b1}
    };

    task automatic run_all();
        int r0, h0;
        // R1: reset state of both units
        cycles(5);
        check("R1", "A standby in reset", sb_a, 1);
        check("R1", "A iso in reset", iso_a, 0);
        check("R1", "A prst in reset", prst_a, 0);
        check("R1", "B standby in reset", sb_b, 1);
        check("R1", "B iso in reset", iso_b, 0);

        // R2/R3/R4: lone unit in slot 2 with peer held in reset, exact decision edge
        slot_a = 2'd2;
        rst_a = 1'b0;
        repeat (3 + 2 * STEP) @(posedge clk);
        @(negedge clk);
        check("R3", "A still waiting one edge before decision", sb_a, 1);
        check("R1", "A iso before decision", iso_a, 0);
        @(posedge clk);
        @(negedge clk);
        check("R3", "A decided on its slot edge", sb_a, 0);
        check("R4", "A drives isolation when active", iso_a, 1);
        check("R2", "free status read as active", sb_a, 0);

        // R5: later unit in the main slot still loses
        slot_b = 2'd0;
        rst_b = 1'b0;
        cycles(400);
        check("R5", "later main-slot unit is standby", sb_b, 1);
        check("R4", "standby unit does not isolate", iso_b, 0);
        check("R5", "first unit stays active", sb_a, 0);

        // Vector table: contention patterns
        foreach (VEC[i]) begin
            rst_a = 1'b1; rst_b = 1'b1;
            slot_a = VEC[i].sa; slot_b = VEC[i].sb;
            cycles(5);
            r0 = rise_a + rise_b;
            for (int t = 0; t <= 600; t++) begin
                if (t == VEC[i].ra) rst_a = 1'b0;
                if (t == VEC[i].rb) rst_b = 1'b0;
                @(negedge clk);
            end
            cycles(800);
            check("R5", $sformatf("vec %0d A role", i), sb_a, VEC[i].ea);
            check("R5", $sformatf("vec %0d B role", i), sb_b, VEC[i].eb);
            check("R4", $sformatf("vec %0d A iso", i), iso_a, !VEC[i].ea);
            check("R4", $sformatf("vec %0d B iso", i), iso_b, !VEC[i].eb);
            check("R6", $sformatf("vec %0d no reset pulse", i), rise_a + rise_b, r0);
        end

        // R6: heartbeats spaced at the timeout never expire it
        per_b = 500;
        r0 = rise_b;
        cycles(3000);
        check("R6", "spacing 500 gives no reset", rise_b - r0, 0);
        check("R6", "roles kept at spacing 500", sb_b, 1);

        // R6/R7/R10/R11: spacing past the timeout triggers a full takeover
        per_b = 520;
        r0 = rise_b;
        h0 = hi_b;
        cycles(1200);
        check("R6", "spacing 520 expires timeout", rise_b - r0, 1);
        check("R7", "reset pulse width", hi_b - h0, RSTW);
        cycles(1000);
        check("R10", "standby took over", sb_b, 0);
        check("R10", "new active isolates", iso_b, 1);
        check("R11", "reset unit settles standby", sb_a, 1);
        check("R11", "reset unit drops isolation", iso_a, 0);
        per_b = 100;

        // R9: active unit without heartbeats never resets its peer
        en_hb_b = 1'b0;
        r0 = rise_b;
        cycles(1500);
        check("R9", "active unit stays quiet", rise_b - r0, 0);
        check("R9", "active unit keeps role", sb_b, 0);
        en_hb_b = 1'b1;

        // R8: board health low suppresses the reset
        ok_a = 1'b0;
        en_hb_a = 1'b0;
        r0 = rise_a;
        cycles(1500);
        check("R8", "no reset while board not ok", rise_a - r0, 0);
        check("R8", "standby kept", sb_a, 1);
        check("R8", "active kept", sb_b, 0);

        // R7/R11: board health returns, expired timeout fires
        ok_a = 1'b1;
        h0 = hi_a;
        cycles(100);
        check("R7", "one reset once board ok", rise_a - r0, 1);
        check("R7", "reset pulse width A", hi_a - h0, RSTW);
        en_hb_a = 1'b1;
        cycles(1000);
        check("R10", "A took over", sb_a, 0);
        check("R11", "B after hard reset is standby", sb_b, 1);

        // R1: reset during operation releases isolation
        rst_a = 1'b1;
        cycles(1);
        check("R1", "reset drops isolation", iso_a, 0);
        check("R1", "reset forces standby", sb_a, 1);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule